// File: doc/BRIEF.md
# Fixed-Point Rounding Quantizer

The quantizer narrows a fixed-point sample to a smaller output format. It removes low fraction bits using one of four rounding modes chosen per sample: floor, ceiling, round-half-up or round-half-to-even. Four parameters fix the binary point at elaboration: the integer and fraction bit counts of the input and of the output. A fifth parameter sets whether the words are two's-complement signed or unsigned. The data word itself carries no marker of the binary point.

An input sample is accepted on any clock where `in_valid` is high. The rounded value, its valid strobe and an overflow flag come out of a single register stage. The rounded value may not fit the output integer field, either because that field is narrower or because the increment carried into it. In that case the output clamps to the nearest end of the output range and the overflow flag marks the sample. If the output keeps at least as many fraction bits as the input, the block only pads zeros below the LSB, and every mode gives the same result. A wider output integer field is filled by sign extension for signed data and by zero extension for unsigned data.

Top module: `qnt_rounder`

## Requirements
- R1: Mode code 2'b00 (floor) discards the dropped fraction bits with no increment, so a two's-complement value rounds toward minus infinity.
- R2: Mode code 2'b01 (ceiling) adds one output LSB when any dropped bit is 1.
- R3: Mode code 2'b10 (half-up) adds one output LSB when the most significant dropped bit is 1.
- R4: Mode code 2'b11 (half-even) matches half-up except on an exact tie (top dropped bit 1, all lower dropped bits 0). On a tie it adds one only if the kept LSB is 1, so the result LSB is 0.
- R5: If the rounded value is above the largest output code, the output becomes that code: 0 followed by all ones when signed, all ones when unsigned. If it is below the smallest code, the output becomes that code: 1 followed by zeros when signed, zero when unsigned. `out_ovf` is 1 with that sample and 0 with every in-range sample.
- R6: `out_valid` is high exactly one clock after each cycle in which `in_valid` is high, and low otherwise. Results leave in the order the samples arrived.
- R7: While `rst_n` is low, `out_valid` and `out_ovf` are 0. They take effect without waiting for a clock edge.
- R8: In a cycle with `in_valid` low, `out_data` keeps its previous value.
- R9: When the output fraction width is at least the input fraction width, the output equals the input with zeros appended below the LSB, extended by sign or zero to the output integer width, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Input sample strobe |
| in_mode | input | 2 | Rounding mode: 00 floor, 01 ceiling, 10 half-up, 11 half-even |
| in_data | input | IN_INT+IN_FRAC | Input sample, value = word x 2^-IN_FRAC |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | OUT_INT+OUT_FRAC | Rounded result, value = word x 2^-OUT_FRAC |
| out_ovf | output | 1 | Result was clamped to the output range |

## Verification
Each mode is driven with a fixed set of inputs:
- exact multiples of the output LSB, which every mode must leave unchanged;
- values one step above and one step below an output LSB, which separate floor from ceiling;
- positive and negative ties whose kept LSB is odd and then even, which separate half-up from half-even.

Further inputs sit at the most negative and most positive codes, and others sit where ceiling or half-up carries past the narrowed integer field, which exercises clamping and the overflow flag. A long pseudo-random stream, with the mode mixed per sample and issued back to back, checks ordering and latency. A second instance, unsigned with a widened format, is swept over every input code in every mode to show pure padding and zero extension.

// File: rtl/qnt_pkg.sv
package qnt_pkg;

  // Mode select codes, fixed by the block's external contract.
  typedef enum logic [1:0] {
    RND_FLOOR     = 2'b00,
    RND_CEIL      = 2'b01,
    RND_HALF_UP   = 2'b10,
    RND_HALF_EVEN = 2'b11
  } rnd_mode_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qnt_rnd_decide.sv
// Decides whether the kept part receives one output LSB.
module qnt_rnd_decide
  import qnt_pkg::*;
(
  input  rnd_mode_e mode,
  input  logic      kept_lsb,
  input  logic      guard,     // most significant dropped bit
  input  logic      sticky,    // OR of the remaining dropped bits
  output logic      inc
);

  always_comb begin
    unique case (mode)
      RND_FLOOR:     inc = 1'b0;
      RND_CEIL:      inc = guard | sticky;
      RND_HALF_UP:   inc = guard;
      RND_HALF_EVEN: inc = guard & (sticky | kept_lsb);
      default:       inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/qnt_align.sv
// Moves the input to output-LSB units: rounds off dropped bits or pads zeros.
module qnt_align
  import qnt_pkg::*;
#(
  parameter bit SIGNED_DATA = 1'b1,
  parameter int IN_W        = 10,
  parameter int IN_FRAC     = 6,
  parameter int OUT_FRAC    = 2,
  parameter int VW          = 7
) (
  input  logic [IN_W-1:0] din,
  input  rnd_mode_e       mode,
  output logic [VW-1:0]   val
);

  localparam int DROP = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;
  localparam int PAD  = (OUT_FRAC > IN_FRAC) ? OUT_FRAC - IN_FRAC : 0;

  if (DROP > 0) begin : g_drop
    localparam int KW = IN_W - DROP;
    logic [KW-1:0] kept;
    logic          guard;
    logic          sticky;
    logic          inc;
    logic          ext_bit;

    assign kept  = din[IN_W-1:DROP];
    assign guard = din[DROP-1];

    if (DROP > 1) begin : g_sticky
      assign sticky = |din[DROP-2:0];
    end else begin : g_nosticky
      assign sticky = 1'b0;
    end

    qnt_rnd_decide u_decide (
      .mode     (mode),
      .kept_lsb (kept[0]),
      .guard    (guard),
      .sticky   (sticky),
      .inc      (inc)
    );

    // One guard bit above the kept field absorbs the carry of the increment.
    assign ext_bit = SIGNED_DATA ? kept[KW-1] : 1'b0;
    assign val     = {ext_bit, kept} + {{KW{1'b0}}, inc};
  end else begin : g_pad
    logic unused_mode;
    assign unused_mode = ^mode;
    if (PAD > 0) begin : g_zeros
      assign val = {din, {PAD{1'b0}}};
    end else begin : g_same
      assign val = din;
    end
  end

endmodule

// File: rtl/qnt_clamp.sv
// Fits a value in output-LSB units into the output word, clamping on overflow.
module qnt_clamp
  import qnt_pkg::*;
#(
  parameter bit SIGNED_DATA = 1'b1,
  parameter int VW          = 7,
  parameter int OW          = 5
) (
  input  logic [VW-1:0] val,
  output logic [OW-1:0] q,
  output logic          ovf
);

  localparam int CW = imax(VW, OW) + 1;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] MAXC = SIGNED_DATA ? ((ONE << (OW - 1)) - ONE)
                                               : ((ONE << OW) - ONE);
  localparam logic [CW-1:0] MINC = SIGNED_DATA ? (~(ONE << (OW - 1)) + ONE)
                                               : '0;

  logic [CW-1:0] ext;
  logic          above;
  logic          below;

  assign ext = SIGNED_DATA ? {{(CW-VW){val[VW-1]}}, val}
                           : {{(CW-VW){1'b0}}, val};

  assign above = $signed(ext) > $signed(MAXC);
  assign below = $signed(ext) < $signed(MINC);

  always_comb begin
    if (above)      q = MAXC[OW-1:0];
    else if (below) q = MINC[OW-1:0];
    else            q = ext[OW-1:0];
  end

  assign ovf = above | below;

endmodule

// File: rtl/qnt_rounder.sv
// Rounding quantizer top: align/round, clamp, one register stage.
module qnt_rounder
  import qnt_pkg::*;
#(
  parameter bit SIGNED_DATA = 1'b1,
  parameter int IN_INT      = 4,
  parameter int IN_FRAC     = 6,
  parameter int OUT_INT     = 3,
  parameter int OUT_FRAC    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [1:0]                  in_mode,
  input  logic [IN_INT+IN_FRAC-1:0]   in_data,
  output logic                        out_valid,
  output logic [OUT_INT+OUT_FRAC-1:0] out_data,
  output logic                        out_ovf
);

  localparam int IN_W  = IN_INT + IN_FRAC;
  localparam int OUT_W = OUT_INT + OUT_FRAC;
  localparam int DROP  = (IN_FRAC > OUT_FRAC) ? IN_FRAC - OUT_FRAC : 0;
  localparam int PAD   = (OUT_FRAC > IN_FRAC) ? OUT_FRAC - IN_FRAC : 0;
  localparam int VW    = (DROP > 0) ? IN_W - DROP + 1 : IN_W + PAD;

  rnd_mode_e        mode_s;
  logic [VW-1:0]    aligned;
  logic [OUT_W-1:0] clamped;
  logic             sat;

  logic             valid_d, valid_q;
  logic             ovf_d,   ovf_q;
  logic [OUT_W-1:0] data_d,  data_q;

  assign mode_s = rnd_mode_e'(in_mode);

  qnt_align #(
    .SIGNED_DATA (SIGNED_DATA),
    .IN_W        (IN_W),
    .IN_FRAC     (IN_FRAC),
    .OUT_FRAC    (OUT_FRAC),
    .VW          (VW)
  ) u_align (
    .din  (in_data),
    .mode (mode_s),
    .val  (aligned)
  );

  qnt_clamp #(
    .SIGNED_DATA (SIGNED_DATA),
    .VW          (VW),
    .OW          (OUT_W)
  ) u_clamp (
    .val (aligned),
    .q   (clamped),
    .ovf (sat)
  );

  // Next-state logic
  always_comb begin
    valid_d = in_valid;
    ovf_d   = in_valid & sat;
    data_d  = in_valid ? clamped : data_q;
  end

  // Control registers: asynchronous active-low reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  // Datapath register: no reset, loads only with a valid sample
  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

  assign out_valid = valid_q;
  assign out_ovf   = ovf_q;
  assign out_data  = data_q;

endmodule

// File: rtl/qnt_rounder_chk.sv
// Temporal checks on the quantizer ports, bound into every instance.
module qnt_rounder_chk #(
  parameter bit SIGNED_DATA = 1'b1,
  parameter int OUT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             out_ovf
);

  localparam logic [OUT_W-1:0] TOP_CODE = SIGNED_DATA ? {1'b0, {(OUT_W-1){1'b1}}}
                                                      : {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] BOT_CODE = SIGNED_DATA ? {1'b1, {(OUT_W-1){1'b0}}}
                                                      : {OUT_W{1'b0}};

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_ovf_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_valid);

  assert_ovf_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> (out_data == TOP_CODE || out_data == BOT_CODE));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_ovf));

endmodule

bind qnt_rounder qnt_rounder_chk #(
  .SIGNED_DATA (SIGNED_DATA),
  .OUT_W       (OUT_INT + OUT_FRAC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ovf   (out_ovf)
);

// File: tb/tb_qnt_rounder.sv
module tb_qnt_rounder;

  localparam int CLK_PERIOD = 10;

  // Instance A: signed, 4.6 -> 3.2 (drops 4 bits, narrower integer field)
  localparam int A_II = 4, A_IF = 6, A_OI = 3, A_OF = 2;
  localparam int A_IW = A_II + A_IF, A_OW = A_OI + A_OF;
  localparam int A_LO = -(1 << (A_OW - 1)), A_HI = (1 << (A_OW - 1)) - 1;
  // Instance B: unsigned, 3.2 -> 5.4 (pads 2 bits, wider integer field)
  localparam int B_II = 3, B_IF = 2, B_OI = 5, B_OF = 4;
  localparam int B_IW = B_II + B_IF, B_OW = B_OI + B_OF;
  localparam int B_LO = 0, B_HI = (1 << B_OW) - 1;

  typedef struct {
    int    val;
    bit    ovf;
    int    due;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic            in_valid_a = 1'b0, in_valid_b = 1'b0;
  logic [1:0]      in_mode_a = '0, in_mode_b = '0;
  logic [A_IW-1:0] in_data_a = '0;
  logic [B_IW-1:0] in_data_b = '0;
  logic            out_valid_a, out_valid_b, out_ovf_a, out_ovf_b;
  logic [A_OW-1:0] out_data_a;
  logic [B_OW-1:0] out_data_b;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q_a[$];
  exp_t q_b[$];
  bit   have_a = 1'b0, have_b = 1'b0;
  logic [A_OW-1:0] last_a;
  logic [B_OW-1:0] last_b;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qnt_rounder #(
    .SIGNED_DATA (1'b1), .IN_INT (A_II), .IN_FRAC (A_IF),
    .OUT_INT (A_OI), .OUT_FRAC (A_OF)
  ) dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid_a), .in_mode (in_mode_a),
    .in_data (in_data_a), .out_valid (out_valid_a), .out_data (out_data_a),
    .out_ovf (out_ovf_a)
  );

  qnt_rounder #(
    .SIGNED_DATA (1'b0), .IN_INT (B_II), .IN_FRAC (B_IF),
    .OUT_INT (B_OI), .OUT_FRAC (B_OF)
  ) dut_pad (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid_b), .in_mode (in_mode_b),
    .in_data (in_data_b), .out_valid (out_valid_b), .out_data (out_data_b),
    .out_ovf (out_ovf_b)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Reference: integer arithmetic on scaled values, remainder compared to half.
  function automatic int ref_q(input int v, input int drop, input int pad,
                               input int lo, input int hi, input int mode,
                               output bit ovf);
    int q, r, half, res;
    if (drop > 0) begin
      q    = v >>> drop;
      r    = v - (q <<< drop);
      half = 1 << (drop - 1);
      case (mode)
        0:       res = q;
        1:       res = q + ((r != 0) ? 1 : 0);
        2:       res = q + ((r >= half) ? 1 : 0);
        default: res = q + (((r > half) || (r == half && (q & 1) != 0)) ? 1 : 0);
      endcase
    end else begin
      res = v <<< pad;
    end
    ovf = (res > hi) || (res < lo);
    if (res > hi) res = hi;
    if (res < lo) res = lo;
    return res;
  endfunction

  function automatic string mode_tag(input int mode);
    case (mode)
      0:       return "R1";
      1:       return "R2";
      2:       return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic drive_a(input int mode, input int v);
    bit o;
    int e;
    @(negedge clk);
    in_valid_b = 1'b0;
    in_valid_a = 1'b1;
    in_mode_a  = 2'(mode);
    in_data_a  = A_IW'(v);
    e = ref_q(v, A_IF - A_OF, 0, A_LO, A_HI, mode, o);
    q_a.push_back('{e, o, cyc + 1, o ? "R5" : mode_tag(mode)});
  endtask

  task automatic drive_b(input int mode, input int v);
    bit o;
    int e;
    @(negedge clk);
    in_valid_a = 1'b0;
    in_valid_b = 1'b1;
    in_mode_b  = 2'(mode);
    in_data_b  = B_IW'(v);
    e = ref_q(v, 0, B_OF - B_IF, B_LO, B_HI, mode, o);
    q_b.push_back('{e, o, cyc + 1, "R9"});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid_a = 1'b0;
    in_valid_b = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor A
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (out_valid_a) begin
        if (q_a.size() == 0) begin
          check(1'b0, "R6 unexpected valid A", 1, 0);
        end else begin
          e = q_a.pop_front();
          check(int'($signed(out_data_a)) == e.val, e.tag, int'($signed(out_data_a)), e.val);
          check(out_ovf_a == e.ovf, "R5 flag", int'(out_ovf_a), int'(e.ovf));
          check(cyc == e.due, "R6 latency", cyc, e.due);
        end
        last_a = out_data_a;
        have_a = 1'b1;
      end else if (have_a) begin
        check(out_data_a == last_a, "R8 hold A", int'(out_data_a), int'(last_a));
        check(!out_ovf_a, "R5 idle flag A", int'(out_ovf_a), 0);
      end
    end
  end

  // Monitor B
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (out_valid_b) begin
        if (q_b.size() == 0) begin
          check(1'b0, "R6 unexpected valid B", 1, 0);
        end else begin
          e = q_b.pop_front();
          check(int'(out_data_b) == e.val, e.tag, int'(out_data_b), e.val);
          check(out_ovf_b == e.ovf, "R9 flag", int'(out_ovf_b), int'(e.ovf));
          check(cyc == e.due, "R6 latency B", cyc, e.due);
        end
        last_b = out_data_b;
        have_b = 1'b1;
      end else if (have_b) begin
        check(out_data_b == last_b, "R8 hold B", int'(out_data_b), int'(last_b));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int vals[18] = '{0, 8, 24, -8, -24, 7, 9, -1, 1, -512, 511, 60, 255, 248,
                     -256, -257, 40, -40};
    logic [31:0] seed = 32'h1234_5678;

    repeat (3) @(negedge clk);
    check(!out_valid_a && !out_ovf_a, "R7 reset A", int'(out_valid_a), 0);
    check(!out_valid_b && !out_ovf_b, "R7 reset B", int'(out_valid_b), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed values for each mode: ties, carries, range ends (R1-R5)
    for (int m = 0; m < 4; m++) begin
      foreach (vals[i]) drive_a(m, vals[i]);
      idle(3);
    end

    // Mixed modes, back to back (R1-R6)
    for (int k = 0; k < 300; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      drive_a(int'(seed[25:24]), int'($signed(seed[17:8])));
      if (seed[30:28] == 3'd0) idle(2);
    end
    idle(3);

    // Padding and zero extension in every mode (R9)
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < (1 << B_IW); v++) drive_b(m, v);
      idle(2);
    end
    idle(3);

    // Asynchronous reset clears valid and flag while a clamped result shows (R7)
    drive_a(1, 255);
    idle(1);
    #1;
    rst_n = 1'b0;
    #1;
    check(!out_valid_a, "R7 async valid", int'(out_valid_a), 0);
    check(!out_ovf_a, "R7 async flag", int'(out_ovf_a), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    check(!out_valid_a, "R7 after release", int'(out_valid_a), 0);

    check(q_a.size() == 0, "R6 missing results A", q_a.size(), 0);
    check(q_b.size() == 0, "R6 missing results B", q_b.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule